// File: doc/BRIEF.md
# Tape Formatter Command Sequencer

This block issues one motion or control command to a magnetic tape formatter and follows the handshake until the formatter accepts it. A host presents a small function code with a one-cycle request strobe. The sequencer turns the code into a formatter command code. It waits until the formatter is no longer busy, then pulses a strobe that clears the controller's error conditions. After that it drives the command onto the formatter command lines and raises a go request. It holds the request until the formatter reports that tape motion has started, then drops it and signals completion.

A separate request pulses the formatter's system-reset line for a fixed number of clock cycles. The formatter's busy and running status arrive asynchronously, so each passes through a two-flop synchroniser before any decision uses it. While a sequence or a reset pulse is in progress, the block shows busy to the host and ignores any new request.

Top module: `tape_cmd_seq`

## Requirements
- R1: During and after a synchronous reset, `fmt_go`, `fmt_errclr`, `fmt_sysrst`, `seq_busy` and `done` are 0 and `fmt_cmd` is 0.
- R2: Accepted function codes map to formatter commands as follows: 0 is rewind (octal 07), 5 is skip one record forward (octal 04), 6 is skip one record backward (octal 05), and 1 is write a file mark (octal 37). The mapped code is on `fmt_cmd` for every cycle that `fmt_go` is high, and `fmt_cmd` is 0 while `fmt_go` is low.
- R3: Function codes 2, 3, 4 and 7 are no-operations. `done` is high in the first cycle after the request, and `fmt_errclr` and `fmt_go` are never raised.
- R4: No error clear is issued while the synchronised busy status is high. If the formatter is already idle, `fmt_errclr` rises 2 cycles after the request. If the formatter is busy, it rises 3 cycles after `st_busy` falls, because of the two-flop synchroniser.
- R5: `fmt_errclr` is high for exactly one cycle per command, and `fmt_go` rises in the cycle after it.
- R6: `fmt_go` stays high until the synchronised running status is seen. It falls 3 cycles after `st_run` rises, and `fmt_cmd` stays constant while it is high.
- R7: `done` is a single-cycle pulse. For an accepted command it comes in the same cycle that `fmt_go` falls.
- R8: `rst_req` raises `fmt_sysrst` for exactly `RST_CYC` cycles. If `rst_req` and `req_valid` arrive in the same cycle, the reset wins and no command is started.
- R9: `seq_busy` is high from the cycle after an accepted command or reset request until the sequence ends. While it is high, `req_valid` and `rst_req` are ignored and start nothing later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle command request strobe |
| req_func | input | 3 | Host function code |
| rst_req | input | 1 | Request a formatter system-reset pulse |
| st_busy | input | 1 | Formatter busy status (asynchronous) |
| st_run | input | 1 | Formatter motion-started status (asynchronous) |
| fmt_cmd | output | 6 | Formatter command code, valid with `fmt_go` |
| fmt_go | output | 1 | Go request to the formatter |
| fmt_errclr | output | 1 | One-cycle controller error-clear strobe |
| fmt_sysrst | output | 1 | Formatter system-reset line |
| seq_busy | output | 1 | A sequence or reset pulse is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound checker checks the output ordering on every cycle: the error clear is single and is always followed by go, go never rises without a preceding clear, the command is stable and non-zero only under go, done is single and never overlaps go, the reset line excludes the other strobes, and the clear never follows a synchronised busy. The exact latencies through the synchroniser, the code mapping, the no-op timing, the reset pulse length and the rejection of requests that arrive mid-sequence are shown only by the bench scenarios. These scenarios use directed and randomised busy and run timings.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int FUNC_W = 3;
  localparam int CMD_W  = 6;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WAIT = 3'd1,
    S_CLR  = 3'd2,
    S_GO   = 3'd3,
    S_RST  = 3'd4
  } seq_state_t;

  // host function codes
  localparam logic [FUNC_W-1:0] F_REWIND = 3'd0;
  localparam logic [FUNC_W-1:0] F_MARK   = 3'd1;
  localparam logic [FUNC_W-1:0] F_FWD    = 3'd5;
  localparam logic [FUNC_W-1:0] F_BACK   = 3'd6;

  // formatter command codes
  localparam logic [CMD_W-1:0] C_REWIND = 6'o07;
  localparam logic [CMD_W-1:0] C_MARK   = 6'o37;
  localparam logic [CMD_W-1:0] C_FWD    = 6'o04;
  localparam logic [CMD_W-1:0] C_BACK   = 6'o05;
endpackage

// File: rtl/tcs_sync.sv
module tcs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/tcs_codemap.sv
module tcs_codemap
  import tcs_pkg::*;
(
  input  logic [FUNC_W-1:0] func,
  output logic [CMD_W-1:0]  cmd,
  output logic              known
);
  always_comb begin
    known = 1'b1;
    case (func)
      F_REWIND: cmd = C_REWIND;
      F_MARK:   cmd = C_MARK;
      F_FWD:    cmd = C_FWD;
      F_BACK:   cmd = C_BACK;
      default: begin
        cmd   = '0;
        known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/tcs_fsm.sv
module tcs_fsm
  import tcs_pkg::*;
#(
  parameter int RST_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             map_known,
  input  logic [CMD_W-1:0] map_cmd,
  input  logic             rst_req,
  input  logic             busy_s,
  input  logic             run_s,
  output logic [CMD_W-1:0] fmt_cmd,
  output logic             fmt_go,
  output logic             fmt_errclr,
  output logic             fmt_sysrst,
  output logic             seq_busy,
  output logic             done
);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  seq_state_t       state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CMD_W-1:0] cmd_q, cmd_n;
  logic             done_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    cmd_n   = cmd_q;
    done_n  = 1'b0;
    case (state)
      S_IDLE: begin
        if (rst_req) begin
          state_n = S_RST;
          cnt_n   = CNT_W'(RST_CYC - 1);
        end else if (req_valid) begin
          if (map_known) begin
            state_n = S_WAIT;
            cmd_n   = map_cmd;
          end else begin
            done_n = 1'b1;
          end
        end
      end
      S_WAIT: if (!busy_s) state_n = S_CLR;
      S_CLR:  state_n = S_GO;
      S_GO: begin
        if (run_s) begin
          state_n = S_IDLE;
          done_n  = 1'b1;
        end
      end
      S_RST: begin
        if (cnt == '0) state_n = S_IDLE;
        else           cnt_n   = cnt - 1'b1;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      cnt        <= '0;
      cmd_q      <= '0;
      fmt_cmd    <= '0;
      fmt_go     <= 1'b0;
      fmt_errclr <= 1'b0;
      fmt_sysrst <= 1'b0;
      seq_busy   <= 1'b0;
      done       <= 1'b0;
    end else begin
      state      <= state_n;
      cnt        <= cnt_n;
      cmd_q      <= cmd_n;
      fmt_cmd    <= (state_n == S_GO) ? cmd_n : '0;
      fmt_go     <= (state_n == S_GO);
      fmt_errclr <= (state_n == S_CLR);
      fmt_sysrst <= (state_n == S_RST);
      seq_busy   <= (state_n != S_IDLE);
      done       <= done_n;
    end
  end
endmodule

// File: rtl/tape_cmd_seq.sv
module tape_cmd_seq
  import tcs_pkg::*;
#(
  parameter int RST_CYC     = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [2:0]       req_func,
  input  logic             rst_req,
  input  logic             st_busy,
  input  logic             st_run,
  output logic [5:0]       fmt_cmd,
  output logic             fmt_go,
  output logic             fmt_errclr,
  output logic             fmt_sysrst,
  output logic             seq_busy,
  output logic             done
);
  logic [1:0]       stat_sync;
  logic             busy_sync;
  logic             run_sync;
  logic [CMD_W-1:0] map_cmd;
  logic             map_known;

  tcs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({st_run, st_busy}),
    .q   (stat_sync)
  );

  assign busy_sync = stat_sync[0];
  assign run_sync  = stat_sync[1];

  tcs_codemap map_i (
    .func  (req_func),
    .cmd   (map_cmd),
    .known (map_known)
  );

  tcs_fsm #(.RST_CYC(RST_CYC)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .map_known  (map_known),
    .map_cmd    (map_cmd),
    .rst_req    (rst_req),
    .busy_s     (busy_sync),
    .run_s      (run_sync),
    .fmt_cmd    (fmt_cmd),
    .fmt_go     (fmt_go),
    .fmt_errclr (fmt_errclr),
    .fmt_sysrst (fmt_sysrst),
    .seq_busy   (seq_busy),
    .done       (done)
  );
endmodule

// File: rtl/tcs_seq_chk.sv
module tcs_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] fmt_cmd,
  input logic       fmt_go,
  input logic       fmt_errclr,
  input logic       fmt_sysrst,
  input logic       seq_busy,
  input logic       done,
  input logic       busy_s
);
  // R5
  errclr_then_go_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_errclr |=> (fmt_go && !fmt_errclr));

  // R5
  go_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fmt_go) |-> $past(fmt_errclr));

  // R6
  cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (fmt_go && $past(fmt_go)) |-> $stable(fmt_cmd));

  // R2
  cmd_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !fmt_go |-> (fmt_cmd == 6'd0));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_not_go_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !fmt_go);

  // R8
  sysrst_excl_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_sysrst |-> (!fmt_go && !fmt_errclr));

  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (fmt_go || fmt_errclr || fmt_sysrst) |-> seq_busy);

  // R4
  clear_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fmt_errclr) |-> !$past(busy_s));
endmodule

bind tape_cmd_seq tcs_seq_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .fmt_cmd    (fmt_cmd),
  .fmt_go     (fmt_go),
  .fmt_errclr (fmt_errclr),
  .fmt_sysrst (fmt_sysrst),
  .seq_busy   (seq_busy),
  .done       (done),
  .busy_s     (busy_sync)
);

// File: tb/tape_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module tape_cmd_seq_tb_top;
  localparam int TB_RST_CYC = 24;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid;
  logic [2:0] req_func;
  logic       rst_req;
  logic       st_busy;
  logic       st_run;
  logic [5:0] fmt_cmd;
  logic       fmt_go, fmt_errclr, fmt_sysrst, seq_busy, done;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  tape_cmd_seq #(.RST_CYC(TB_RST_CYC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_func(req_func),
    .rst_req(rst_req), .st_busy(st_busy), .st_run(st_run),
    .fmt_cmd(fmt_cmd), .fmt_go(fmt_go), .fmt_errclr(fmt_errclr),
    .fmt_sysrst(fmt_sysrst), .seq_busy(seq_busy), .done(done)
  );

  function automatic bit exp_known(input logic [2:0] f);
    return (f == 3'd0) || (f == 3'd1) || (f == 3'd5) || (f == 3'd6);
  endfunction

  function automatic logic [5:0] exp_cmd(input logic [2:0] f);
    case (f)
      3'd0: return 6'o07;
      3'd1: return 6'o37;
      3'd5: return 6'o04;
      3'd6: return 6'o05;
      default: return 6'o00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_cmd(input logic [2:0] f, input int busy_hold,
                         input int run_lag, input bit intrude);
    bit ok;
    logic [5:0] ecmd;
    int c, clr_at, clr_n, go_n, done_at, bad_cmd, exp_clr;
    bit go_early, sys_seen, busy_gap, done_go;
    ok = exp_known(f);
    ecmd = exp_cmd(f);
    clr_at = -1; clr_n = 0; go_n = 0; done_at = -1; bad_cmd = -1;
    go_early = 0; sys_seen = 0; busy_gap = 0; done_go = 0;
    st_run = 1'b0;
    if (busy_hold > 0) begin
      st_busy = 1'b1;
      repeat (3) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b1;
    req_func  = f;
    c = 0;
    while (c < 400) begin
      @(negedge clk);
      c++;
      req_valid = 1'b0;
      rst_req   = 1'b0;
      if (intrude && c == 2) begin req_valid = 1'b1; req_func = 3'd5; end
      if (intrude && c == 3) rst_req = 1'b1;
      if (fmt_sysrst) sys_seen = 1;
      if (fmt_errclr) begin
        clr_n++;
        if (clr_at < 0) clr_at = c;
      end
      if (fmt_go) begin
        if (clr_at < 0) go_early = 1;
        go_n++;
        if (fmt_cmd !== ecmd) bad_cmd = int'(fmt_cmd);
        if (go_n == run_lag) st_run = 1'b1;
      end
      if (ok && !done && !seq_busy) busy_gap = 1;
      if (done) begin
        done_at = c;
        done_go = fmt_go;
        break;
      end
      if (busy_hold > 0 && c == busy_hold) st_busy = 1'b0;
    end
    st_run  = 1'b0;
    st_busy = 1'b0;
    if (ok) begin
      exp_clr = (busy_hold > 0) ? busy_hold + 3 : 2;
      chk(clr_at == exp_clr, "R4 clear timing", clr_at, exp_clr);
      chk(clr_n == 1 && !go_early, "R5 single clear before go", clr_n, 1);
      chk(go_n == run_lag + 2, "R6 go length", go_n, run_lag + 2);
      chk(bad_cmd < 0 && go_n > 0, "R2 command code", bad_cmd, int'(ecmd));
      chk(done_at > 0 && !done_go, "R7 done as go falls", done_at, exp_clr + run_lag + 3);
      chk(!busy_gap, "R9 busy during sequence", 0, 1);
      if (intrude) chk(!sys_seen, "R9 reset ignored while busy", 1, 0);
    end else begin
      chk(done_at == 1, "R3 no-op done timing", done_at, 1);
      chk(clr_n == 0 && go_n == 0, "R3 no-op strobes", clr_n + go_n, 0);
    end
    @(negedge clk);
    chk(!done && !seq_busy, "R7 done single and idle after", int'(done) + int'(seq_busy), 0);
    if (intrude) begin
      int stray = 0;
      repeat (8) begin
        @(negedge clk);
        if (fmt_go || fmt_errclr || fmt_sysrst || seq_busy) stray++;
      end
      chk(stray == 0, "R9 ignored request started nothing", stray, 0);
    end
  endtask

  task automatic run_reset(input bit with_cmd);
    int hi = 0;
    bit strobe = 0, busy_lo = 0;
    @(negedge clk);
    rst_req = 1'b1;
    if (with_cmd) begin req_valid = 1'b1; req_func = 3'd0; end
    @(negedge clk);
    rst_req = 1'b0;
    req_valid = 1'b0;
    for (int k = 0; k < TB_RST_CYC + 20; k++) begin
      if (fmt_sysrst) begin
        hi++;
        if (!seq_busy) busy_lo = 1;
      end
      if (fmt_go || fmt_errclr || done) strobe = 1;
      @(negedge clk);
    end
    chk(hi == TB_RST_CYC, "R8 reset pulse length", hi, TB_RST_CYC);
    chk(!strobe, "R8 reset wins over command", 1, 0);
    chk(!busy_lo && !seq_busy, "R9 busy during reset pulse", int'(busy_lo), 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; req_valid = 1'b0; req_func = 3'd0; rst_req = 1'b0;
    st_busy = 1'b0; st_run = 1'b0;
    repeat (4) @(negedge clk);
    chk(!fmt_go && !fmt_errclr && !fmt_sysrst && !seq_busy && !done && fmt_cmd == 6'd0,
        "R1 outputs in reset", int'(fmt_go) + int'(seq_busy), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!fmt_go && !fmt_errclr && !fmt_sysrst && !seq_busy && !done,
        "R1 outputs after reset", int'(fmt_go) + int'(seq_busy), 0);

    // directed: each mapped code, idle and busy formatter
    run_cmd(3'd0, 0, 1, 0);
    run_cmd(3'd5, 4, 2, 0);
    run_cmd(3'd6, 1, 3, 0);
    run_cmd(3'd1, 7, 1, 0);
    // no-op codes
    run_cmd(3'd2, 0, 1, 0);
    run_cmd(3'd7, 0, 1, 0);
    // requests during a sequence are ignored
    run_cmd(3'd0, 6, 2, 1);
    // reset pulse, alone and racing a command
    run_reset(0);
    run_reset(1);

    for (int i = 0; i < 40; i++) begin
      logic [2:0] f;
      int bh, rl;
      f  = 3'($urandom_range(0, 7));
      bh = int'($urandom_range(0, 6));
      rl = int'($urandom_range(1, 5));
      run_cmd(f, bh, rl, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule